// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block keeps the modem status byte of a 16550-class serial port. Four active-low modem lines (clear-to-send, data-set-ready, ring, carrier-detect) pass through a synchronizer. Their inverted levels form the upper nibble of the byte. The lower nibble holds sticky change flags that a processor read clears. A loop-back select takes the upper nibble from four modem-control outputs of the port instead of the pins. Each time the selected source alters a status bit, its change flag is set.

Any set change flag raises an interrupt request, gated by an enable input. A transmit gate is also provided. When hardware flow control is on, a new character may start only at a character boundary while the clear-to-send status is asserted. A character already on the line therefore always completes.

The control and status pins are plain levels. The block carries no streaming data path, so it has no valid/ready handshake.

Top module: `modem_status_reg`

## Requirements
- R1: With `loop_en`=0, `rd_data[7:4]` = {~dcd_n, ~ri_n, ~dsr_n, ~cts_n} (bit 7 carrier, bit 6 ring, bit 5 data-set-ready, bit 4 clear-to-send). It reflects a pin change two clock edges after the change.
- R2: With `loop_en`=1, `rd_data[7:4]` = {mcr_out2, mcr_out1, mcr_dtr, mcr_rts} in the same cycle, and the pins have no effect on it.
- R3: Change flags `rd_data[3]` (carrier), `rd_data[1]` (data-set-ready) and `rd_data[0]` (clear-to-send) set on any change of their status bit, in either direction. For a pin this happens three edges after the change, and for a loop-back source one edge after.
- R4: Ring change flag `rd_data[2]` sets only when status bit 6 goes from 1 to 0, that is, when the ring pin rises from 0 to 1. The opposite transition leaves it unchanged.
- R5: `rd_data` is combinational, so a read returns the flags as they are before the clear. The clock edge with `rd_stb`=1 clears all four flags. Without a read, a set flag stays set.
- R6: A change detected at the same edge as a clearing read leaves its flag set.
- R7: Toggling `loop_en` runs change detection on the newly selected source, so a status bit altered by the switch sets its flag.
- R8: `irq_o` = `ms_irq_en` AND (OR of the four change flags).
- R9: `tx_start_o` = `tx_pending` AND `tx_boundary` AND NOT(`flow_en` AND NOT `rd_data[4]`). A character can therefore be stopped only at a boundary.
- R10: After reset all flags and `irq_o` are 0. Pin levels already present at reset set no flag, and the upper nibble shows those levels once settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| loop_en | input | 1 | Loop-back select |
| mcr_rts | input | 1 | Loop-back source for bit 4 |
| mcr_dtr | input | 1 | Loop-back source for bit 5 |
| mcr_out1 | input | 1 | Loop-back source for bit 6 |
| mcr_out2 | input | 1 | Loop-back source for bit 7 |
| rd_stb | input | 1 | Processor read strobe, clears the flags |
| rd_data | output | 8 | Status byte |
| ms_irq_en | input | 1 | Modem-status interrupt enable |
| irq_o | output | 1 | Modem-status interrupt request |
| flow_en | input | 1 | Hardware clear-to-send flow control enable |
| tx_pending | input | 1 | Transmitter has a character waiting |
| tx_boundary | input | 1 | Transmitter is between characters |
| tx_start_o | output | 1 | Permission to start the next character |

## Verification
A pin change appears in the status nibble after two edges and in the change flags after three. A loop-back source appears in the status nibble in the same cycle and in the flags after one edge. The bench drives inputs just after a falling edge and counts the rising edges to each result. It samples the status nibble after two of them and the flags after three, and it also confirms that the flags are still clear one edge early. The read data is sampled while the strobe is high, before the clearing edge, and the cleared value is sampled one edge later. The transmit gate is checked once the synchronized clear-to-send level has settled.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int NUM_LINES = 4;
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;
  typedef logic [NUM_LINES-1:0] line_vec_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '1;
    else        stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '1;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/msr_delta.sv
module msr_delta
  import msr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      arm_i,
  input  line_vec_t src_i,
  input  logic      clr_i,
  output line_vec_t delta_o,
  output line_vec_t chg_o
);
  line_vec_t prev_q, delta_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (i == LN_RI) begin : g_fall
      assign chg_o[i] = arm_i & prev_q[i] & ~src_i[i];
    end else begin : g_any
      assign chg_o[i] = arm_i & (prev_q[i] ^ src_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= src_i;
      delta_q <= (clr_i ? '0 : delta_q) | chg_o;
    end
  end

  assign delta_o = delta_q;
endmodule

// File: rtl/msr_flow.sv
module msr_flow (
  input  logic flow_en_i,
  input  logic cts_st_i,
  input  logic pending_i,
  input  logic boundary_i,
  output logic start_o
);
  logic hold;
  assign hold    = flow_en_i & ~cts_st_i;
  assign start_o = pending_i & boundary_i & ~hold;
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  input  logic       loop_en,
  input  logic       mcr_rts,
  input  logic       mcr_dtr,
  input  logic       mcr_out1,
  input  logic       mcr_out2,
  input  logic       rd_stb,
  output logic [7:0] rd_data,
  input  logic       ms_irq_en,
  output logic       irq_o,
  input  logic       flow_en,
  input  logic       tx_pending,
  input  logic       tx_boundary,
  output logic       tx_start_o
);
  localparam int SETTLE = SYNC_STAGES + 1;
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] SETTLE_V = CW'(SETTLE);

  line_vec_t pins_n, sync_n, st_pin, st_loop, src, delta, chg;
  logic [CW-1:0] settle_q;
  logic arm;

  assign pins_n[LN_CTS] = cts_n;
  assign pins_n[LN_DSR] = dsr_n;
  assign pins_n[LN_RI]  = ri_n;
  assign pins_n[LN_DCD] = dcd_n;

  assign st_loop[LN_CTS] = mcr_rts;
  assign st_loop[LN_DSR] = mcr_dtr;
  assign st_loop[LN_RI]  = mcr_out1;
  assign st_loop[LN_DCD] = mcr_out2;

  msr_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_n), .q_o(sync_n)
  );

  assign st_pin = ~sync_n;
  assign src    = loop_en ? st_loop : st_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                settle_q <= '0;
    else if (settle_q != SETTLE_V) settle_q <= settle_q + 1'b1;
  end
  assign arm = (settle_q == SETTLE_V);

  msr_delta u_delta (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .src_i(src),
    .clr_i(rd_stb), .delta_o(delta), .chg_o(chg)
  );

  msr_flow u_flow (
    .flow_en_i(flow_en), .cts_st_i(src[LN_CTS]), .pending_i(tx_pending),
    .boundary_i(tx_boundary), .start_o(tx_start_o)
  );

  assign rd_data = {src[LN_DCD], src[LN_RI], src[LN_DSR], src[LN_CTS],
                    delta[LN_DCD], delta[LN_RI], delta[LN_DSR], delta[LN_CTS]};
  assign irq_o   = ms_irq_en & (|delta);
endmodule

// File: rtl/msr_chk.sv
module msr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb,
  input logic [7:0] rd_data,
  input logic       irq_o,
  input logic       ms_irq_en,
  input logic       loop_en,
  input logic [3:0] loop_src,
  input logic       flow_en,
  input logic       tx_start_o,
  input logic       chg_any
);
  AST_LOOP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> rd_data[7:4] == loop_src); // R2
  AST_RING_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[2]) |-> !$past(rd_data[6])); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !chg_any) |=> rd_data[3:0] == 4'h0); // R5
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0]))); // R5
  AST_CHANGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && chg_any) |=> rd_data[3:0] != 4'h0); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_irq_en |-> !irq_o); // R8
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> rd_data[3:0] != 4'h0); // R8
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && !rd_data[4]) |-> !tx_start_o); // R9
endmodule

bind modem_status_reg msr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_data(rd_data),
  .irq_o(irq_o), .ms_irq_en(ms_irq_en), .loop_en(loop_en),
  .loop_src({mcr_out2, mcr_out1, mcr_dtr, mcr_rts}),
  .flow_en(flow_en), .tx_start_o(tx_start_o), .chg_any(|chg)
);

// File: tb/modem_status_reg_tb.sv
module modem_status_reg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pn = 4'hF;   // {dcd, ri, dsr, cts}
  logic [3:0] mcr = 4'h0;  // {out2, out1, dtr, rts}
  logic loop_en = 1'b0, rd_stb = 1'b0, ms_irq_en = 1'b1;
  logic flow_en = 1'b0, tx_pending = 1'b0, tx_boundary = 1'b0;
  logic [7:0] rd_data;
  logic irq_o, tx_start_o;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  modem_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .cts_n(pn[0]), .dsr_n(pn[1]), .ri_n(pn[2]),
    .dcd_n(pn[3]), .loop_en(loop_en), .mcr_rts(mcr[0]), .mcr_dtr(mcr[1]),
    .mcr_out1(mcr[2]), .mcr_out2(mcr[3]), .rd_stb(rd_stb), .rd_data(rd_data),
    .ms_irq_en(ms_irq_en), .irq_o(irq_o), .flow_en(flow_en),
    .tx_pending(tx_pending), .tx_boundary(tx_boundary), .tx_start_o(tx_start_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [3:0] dexp(input logic [3:0] o, input logic [3:0] n);
    return {o[3] ^ n[3], o[2] & ~n[2], o[1] ^ n[1], o[0] ^ n[0]};
  endfunction

  task automatic do_read();
    rd_stb = 1'b1; tick(1); rd_stb = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1'b1; tick(6);
    chk("R10 reset byte", rd_data, 8'h00);
    chk("R10 reset irq", {7'd0, irq_o}, 8'h00);

    // R1 R3 R4 R5 R8: every pin-pattern transition
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [3:0] ex;
        pn = 4'(a); tick(3); do_read();
        pn = 4'(b); tick(2);
        chk("R1 status after two edges", {4'd0, rd_data[7:4]}, {4'd0, ~4'(b)});
        chk("R3 flags not yet set", {4'd0, rd_data[3:0]}, 8'h00);
        tick(1);
        ex = dexp(~4'(a), ~4'(b));
        chk("R3_R4 change flags", {4'd0, rd_data[3:0]}, {4'd0, ex});
        chk("R8 irq", {7'd0, irq_o}, {7'd0, |ex});
        rd_stb = 1'b1;
        chk("R5 read sees pre-clear", {4'd0, rd_data[3:0]}, {4'd0, ex});
        tick(1); rd_stb = 1'b0;
        chk("R5 cleared by read", {4'd0, rd_data[3:0]}, 8'h00);
      end
    end

    // R5 sticky and R8 gating
    pn = 4'hF; tick(3); do_read();
    pn = 4'hE; tick(8);
    chk("R5 sticky flag", {4'd0, rd_data[3:0]}, 8'h01);
    ms_irq_en = 1'b0; tick(1);
    chk("R8 irq masked", {7'd0, irq_o}, 8'h00);
    ms_irq_en = 1'b1; tick(1);
    chk("R8 irq enabled", {7'd0, irq_o}, 8'h01);

    // R6: change lands on the clearing edge
    pn = 4'hF; tick(3); do_read();
    pn = 4'hD; tick(3);
    pn = 4'hC; tick(2);
    rd_stb = 1'b1;
    chk("R6 pre-clear value", {4'd0, rd_data[3:0]}, 8'h02);
    tick(1); rd_stb = 1'b0;
    chk("R6 new change kept", {4'd0, rd_data[3:0]}, 8'h01);

    // R2: loop-back sweep
    pn = 4'hF; tick(3); do_read();
    loop_en = 1'b1; mcr = 4'h0; tick(1); do_read();
    for (int m = 1; m < 17; m++) begin
      logic [3:0] old;
      old = mcr;
      mcr = 4'(m); pn = 4'(m * 5); #1;
      chk("R2 loop source", {4'd0, rd_data[7:4]}, {4'd0, 4'(m)});
      tick(1);
      chk("R2_R3 loop flags", {4'd0, rd_data[3:0]}, {4'd0, dexp(old, 4'(m))});
      do_read();
    end

    // R7: mode switch changes source
    loop_en = 1'b0; pn = 4'h0; mcr = 4'h0; tick(4); do_read();
    loop_en = 1'b1; tick(1);
    chk("R7 enter loop flags", {4'd0, rd_data[3:0]}, 8'h0F);
    do_read();
    loop_en = 1'b0; tick(1);
    chk("R7 leave loop flags", {4'd0, rd_data[3:0]}, 8'h0B);
    do_read();

    // R9: transmit gate, pin mode then loop mode
    for (int v = 0; v < 16; v++) begin
      flow_en = v[3]; tx_pending = v[2]; tx_boundary = v[1];
      pn = {3'b111, v[0]}; tick(2);
      chk("R9 gate pin", {7'd0, tx_start_o}, {7'd0, v[2] & v[1] & ~(v[3] & v[0])});
    end
    loop_en = 1'b1;
    for (int v = 0; v < 16; v++) begin
      flow_en = v[3]; tx_pending = v[2]; tx_boundary = v[1];
      mcr = {3'b000, v[0]}; pn = {3'b111, ~v[0]}; tick(1);
      chk("R9 gate loop", {7'd0, tx_start_o}, {7'd0, v[2] & v[1] & ~(v[3] & ~v[0])});
    end
    loop_en = 1'b0; flow_en = 1'b0;

    // R10: reset with all pins asserted
    rst_n = 1'b0; pn = 4'h0; tick(3); rst_n = 1'b1; tick(6);
    chk("R10 settled byte", rd_data, 8'hF0);
    chk("R10 settled irq", {7'd0, irq_o}, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule